// File: doc/BRIEF.md
# Thermal sensor auto-scan monitor

The block samples up to four temperature-sensor converter channels on its own. It runs a tick-driven interval timer. When the interval ends, it requests one conversion per channel in ascending channel order over a request/acknowledge handshake. It stores each result, and it can optionally report the result as 1024 minus the raw code. Each result is compared against two limits for its channel: an alarm limit and a shutdown limit. Each comparison has its own counter of consecutive over-limit samples.

An alarm becomes pending once its counter reaches the programmed alarm count. Pending alarms drive a maskable interrupt. A shutdown condition is latched until reset once its counter reaches the shutdown count, provided shutdown checking is enabled for that channel. The latched shutdown is steered per channel to a reset-controller output and/or a GPIO output, with a selectable active level.

While the latest reading of every channel is below both limits, the interval uses the normal period. As soon as any latest reading is over a limit, the interval uses the shorter high-temperature period. Software reaches everything through a flat word-addressed register bus: byte address, 32-bit write data, write enable, and combinational read data.

Top module: `thermal_scan_mon`

## Requirements
- R1: After reset, irq_o is 0, both shutdown outputs are 1 (active low, inactive), no conversion is requested, the control word at 0x04 reads 0, both count registers (0x60 alarm, 0x64 shutdown) read 4, the period registers read 250 (0x68 normal) and 50 (0x6C high) ticks, and the compare registers read all ones.
- R2: With scanning enabled (0x04 bit 0), the block counts tick_i pulses while idle. After exactly the selected period (0 counts as 1), it requests channels 0 to NUM_CH-1 in order. Each request holds conv_ch_o until conv_ack_i, which also carries the data.
- R3: The period at 0x68 is used while no channel's latest sample exceeds its alarm or shutdown limit. The period at 0x6C is used while any channel's latest sample does.
- R4: The sample is readable at 0x20+4·ch. When 0x04 bit 1 is set, the stored and compared value is (1024 − raw) modulo 2^DATA_W.
- R5: With INCREASING=1, a sample exceeds a limit only when it is strictly greater than the limit. A sample equal to the limit does not exceed it. With INCREASING=0, the sample must be strictly smaller.
- R6: Each channel's alarm counter (limit at 0x30+4·ch) adds one for an exceeding sample, saturating, and returns to 0 for any other sample. Pending bit ch at 0x0C sets on a sample where the new count is at least the value at 0x60.
- R7: irq_o is 1 exactly when some pending alarm bit ch is 1 and its enable bit ch at 0x08 is 1.
- R8: Writing 1 to pending bit ch clears it. If a sample sets the same bit in the same cycle, the bit stays set. The shutdown status bit (bit 8 for DATA_W above 10, else bit 16) reads 1 while any shutdown is latched, and writes do not change it.
- R9: A channel latches shutdown when 0x04 bit 4+ch is 1 and its shutdown counter (limit 0x40+4·ch, count 0x64, same counting rule as R6) reaches the count. Bit 4+ch of 0x08 routes the channel to tshut_gpio_o, and bit 8+ch routes it to tshut_cru_o.
- R10: 0x04 bit 8 = 1 makes the shutdown outputs active high; 0 makes them active low.
- R11: A latched shutdown stays asserted until reset, even after samples fall below the limit.
- R12: While 0x04 bit 0 is 0, conv_req_o stays 0 and the interval count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Register write data |
| we_i | input | 1 | Register write strobe |
| rdata_o | output | 32 | Read data for addr_i |
| tick_i | input | 1 | Timebase pulse for the scan interval |
| conv_req_o | output | 1 | Conversion request |
| conv_ch_o | output | CH_W | Channel being converted |
| conv_ack_i | input | 1 | Conversion done, data valid |
| conv_data_i | input | DATA_W | Raw converter code |
| irq_o | output | 1 | Alarm interrupt |
| tshut_cru_o | output | 1 | Shutdown toward the reset controller |
| tshut_gpio_o | output | 1 | Shutdown toward the GPIO path |

## Verification
A software clear of a pending alarm can land in the same cycle as the conversion acknowledge that sets that alarm again. The bench holds a channel over its limit until its counter saturates. It then waits until it sees conv_ack_i for channel 0 between clock edges and drives the clear write into that same edge. It expects the bit to read 1 right afterwards. A clear issued while the scanner is idle is expected to read 0. The per-clock reference model applies clear and set in the same order, so irq_o is compared on every cycle around both events.

// File: rtl/thermal_scan_pkg.sv
package thermal_scan_pkg;
  localparam logic [7:0] A_USER  = 8'h00;
  localparam logic [7:0] A_AUTO  = 8'h04;
  localparam logic [7:0] A_INTEN = 8'h08;
  localparam logic [7:0] A_PEND  = 8'h0C;
  localparam logic [7:0] A_DATA0 = 8'h20;
  localparam logic [7:0] A_ALRM0 = 8'h30;
  localparam logic [7:0] A_SHUT0 = 8'h40;
  localparam logic [7:0] A_ADEB  = 8'h60;
  localparam logic [7:0] A_SDEB  = 8'h64;
  localparam logic [7:0] A_PNORM = 8'h68;
  localparam logic [7:0] A_PHOT  = 8'h6C;

  localparam int B_EN    = 0;
  localparam int B_QSEL  = 1;
  localparam int B_SHCHK = 4;
  localparam int B_POL   = 8;
  localparam int B_GPIO  = 4;
  localparam int B_CRU   = 8;

  typedef enum logic {ST_WAIT, ST_SCAN} scan_st_e;
endpackage

// File: rtl/tsm_scheduler.sv
module tsm_scheduler
  import thermal_scan_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int PER_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] per_norm_i,
  input  logic [PER_W-1:0] per_hot_i,
  input  logic             hot_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [CH_W-1:0]  ch_o,
  output logic             smp_vld_o
);
  scan_st_e        state_q;
  logic [PER_W-1:0] cnt_q;
  logic [CH_W-1:0]  ch_q;
  logic [PER_W-1:0] per_sel;
  logic             expire;

  assign per_sel = hot_i ? per_hot_i : per_norm_i;
  assign expire  = ((PER_W+1)'(cnt_q) + 1'b1) >= (PER_W+1)'(per_sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      ch_q    <= '0;
    end else if (!en_i) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      ch_q    <= '0;
    end else begin
      case (state_q)
        ST_WAIT: if (tick_i) begin
          if (expire) begin
            state_q <= ST_SCAN;
            cnt_q   <= '0;
            ch_q    <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: if (ack_i) begin
          if (ch_q == CH_W'(NUM_CH - 1)) state_q <= ST_WAIT;
          else                           ch_q    <= ch_q + 1'b1;
        end
      endcase
    end
  end

  assign req_o     = (state_q == ST_SCAN);
  assign ch_o      = ch_q;
  assign smp_vld_o = req_o & ack_i;

  p_req_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !req_o);
  p_ch_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && req_o && !ack_i) |=> (req_o && $stable(ch_o)));
endmodule

// File: rtl/tsm_chan_eval.sv
module tsm_chan_eval #(
  parameter int DATA_W     = 12,
  parameter int DEB_W      = 8,
  parameter bit INCREASING = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] alarm_cmp_i,
  input  logic [DATA_W-1:0] shut_cmp_i,
  input  logic [DEB_W-1:0]  alarm_deb_i,
  input  logic [DEB_W-1:0]  shut_deb_i,
  input  logic              shut_chk_i,
  output logic              alarm_hit_o,
  output logic              shut_lat_o,
  output logic              hot_o
);
  logic             exc_a, exc_s, shut_fire;
  logic [DEB_W-1:0] acnt_q, scnt_q, acnt_nxt, scnt_nxt;
  logic             shut_q, hot_q;

  generate
    if (INCREASING) begin : g_inc
      assign exc_a = data_i > alarm_cmp_i;
      assign exc_s = data_i > shut_cmp_i;
    end else begin : g_dec
      assign exc_a = data_i < alarm_cmp_i;
      assign exc_s = data_i < shut_cmp_i;
    end
  endgenerate

  // saturating run-length of consecutive over-limit samples
  assign acnt_nxt = !exc_a ? '0 : (&acnt_q ? acnt_q : acnt_q + 1'b1);
  assign scnt_nxt = !exc_s ? '0 : (&scnt_q ? scnt_q : scnt_q + 1'b1);

  assign alarm_hit_o = smp_i && exc_a && (acnt_nxt >= alarm_deb_i);
  assign shut_fire   = smp_i && shut_chk_i && exc_s && (scnt_nxt >= shut_deb_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acnt_q <= '0;
      scnt_q <= '0;
      shut_q <= 1'b0;
      hot_q  <= 1'b0;
    end else begin
      if (smp_i) begin
        acnt_q <= acnt_nxt;
        scnt_q <= scnt_nxt;
        hot_q  <= exc_a | exc_s;
      end
      if (shut_fire) shut_q <= 1'b1;
    end
  end

  assign shut_lat_o = shut_q;
  assign hot_o      = hot_q;

  p_shut_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut_q |=> shut_q);
  p_dbc_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i && !exc_a) |=> (acnt_q == '0));
endmodule

// File: rtl/tsm_regs.sv
module tsm_regs
  import thermal_scan_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int DATA_W      = 12,
  parameter int DEB_W       = 8,
  parameter int PER_W       = 16,
  parameter bit INCREASING  = 1'b1,
  parameter int SHUT_PD_BIT = 8,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [7:0]                    addr_i,
  input  logic [31:0]                   wdata_i,
  input  logic                          we_i,
  output logic [31:0]                   rdata_o,
  input  logic                          smp_vld_i,
  input  logic [CH_W-1:0]               smp_ch_i,
  input  logic [DATA_W-1:0]             smp_data_i,
  input  logic [NUM_CH-1:0]             alarm_hit_i,
  input  logic                          shut_any_i,
  output logic                          auto_en_o,
  output logic                          qsel_o,
  output logic                          pol_o,
  output logic [NUM_CH-1:0]             shut_chk_o,
  output logic [NUM_CH-1:0]             int_en_o,
  output logic [NUM_CH-1:0]             gpio_rt_o,
  output logic [NUM_CH-1:0]             cru_rt_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] alarm_cmp_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] shut_cmp_o,
  output logic [DEB_W-1:0]              alarm_deb_o,
  output logic [DEB_W-1:0]              shut_deb_o,
  output logic [PER_W-1:0]              per_norm_o,
  output logic [PER_W-1:0]              per_hot_o,
  output logic [NUM_CH-1:0]             pend_o
);
  localparam logic [DATA_W-1:0] CMP_RST = INCREASING ? '1 : '0;

  logic [31:0]                   user_q;
  logic [15:0]                   auto_q, inten_q;
  logic [NUM_CH-1:0]             pend_q, pclr;
  logic [NUM_CH-1:0][DATA_W-1:0] data_q, acmp_q, scmp_q;
  logic [DEB_W-1:0]              adeb_q, sdeb_q;
  logic [PER_W-1:0]              pnorm_q, phot_q;

  assign pclr = (we_i && addr_i == A_PEND) ? wdata_i[NUM_CH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      user_q  <= '0;
      auto_q  <= '0;
      inten_q <= '0;
      pend_q  <= '0;
      adeb_q  <= DEB_W'(4);
      sdeb_q  <= DEB_W'(4);
      pnorm_q <= PER_W'(250);
      phot_q  <= PER_W'(50);
      for (int c = 0; c < NUM_CH; c++) begin
        data_q[c] <= '0;
        acmp_q[c] <= CMP_RST;
        scmp_q[c] <= CMP_RST;
      end
    end else begin
      pend_q <= (pend_q & ~pclr) | alarm_hit_i;  // set wins
      if (smp_vld_i) data_q[smp_ch_i] <= smp_data_i;
      if (we_i) begin
        if (addr_i == A_USER)  user_q  <= wdata_i;
        if (addr_i == A_AUTO)  auto_q  <= wdata_i[15:0];
        if (addr_i == A_INTEN) inten_q <= wdata_i[15:0];
        if (addr_i == A_ADEB)  adeb_q  <= wdata_i[DEB_W-1:0];
        if (addr_i == A_SDEB)  sdeb_q  <= wdata_i[DEB_W-1:0];
        if (addr_i == A_PNORM) pnorm_q <= wdata_i[PER_W-1:0];
        if (addr_i == A_PHOT)  phot_q  <= wdata_i[PER_W-1:0];
        for (int c = 0; c < NUM_CH; c++) begin
          if (addr_i == 8'(A_ALRM0 + 4*c)) acmp_q[c] <= wdata_i[DATA_W-1:0];
          if (addr_i == 8'(A_SHUT0 + 4*c)) scmp_q[c] <= wdata_i[DATA_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_USER)  rdata_o = user_q;
    if (addr_i == A_AUTO)  rdata_o = 32'(auto_q);
    if (addr_i == A_INTEN) rdata_o = 32'(inten_q);
    if (addr_i == A_PEND)  rdata_o = 32'(pend_q) | (32'(shut_any_i) << SHUT_PD_BIT);
    if (addr_i == A_ADEB)  rdata_o = 32'(adeb_q);
    if (addr_i == A_SDEB)  rdata_o = 32'(sdeb_q);
    if (addr_i == A_PNORM) rdata_o = 32'(pnorm_q);
    if (addr_i == A_PHOT)  rdata_o = 32'(phot_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == 8'(A_DATA0 + 4*c)) rdata_o = 32'(data_q[c]);
      if (addr_i == 8'(A_ALRM0 + 4*c)) rdata_o = 32'(acmp_q[c]);
      if (addr_i == 8'(A_SHUT0 + 4*c)) rdata_o = 32'(scmp_q[c]);
    end
  end

  assign auto_en_o   = auto_q[B_EN];
  assign qsel_o      = auto_q[B_QSEL];
  assign pol_o       = auto_q[B_POL];
  assign shut_chk_o  = auto_q[B_SHCHK +: NUM_CH];
  assign int_en_o    = inten_q[NUM_CH-1:0];
  assign gpio_rt_o   = inten_q[B_GPIO +: NUM_CH];
  assign cru_rt_o    = inten_q[B_CRU +: NUM_CH];
  assign alarm_cmp_o = acmp_q;
  assign shut_cmp_o  = scmp_q;
  assign alarm_deb_o = adeb_q;
  assign shut_deb_o  = sdeb_q;
  assign per_norm_o  = pnorm_q;
  assign per_hot_o   = phot_q;
  assign pend_o      = pend_q;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_pchk
      p_pend_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_q[c]) |-> $past(alarm_hit_i[c]));
    end
  endgenerate
endmodule

// File: rtl/thermal_scan_mon.sv
module thermal_scan_mon #(
  parameter int NUM_CH     = 2,
  parameter int DATA_W     = 12,
  parameter int DEB_W      = 8,
  parameter int PER_W      = 16,
  parameter bit INCREASING = 1'b1,
  localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SHUT_PD_BIT = (DATA_W > 10) ? 8 : 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  output logic [31:0]       rdata_o,
  input  logic              tick_i,
  output logic              conv_req_o,
  output logic [CH_W-1:0]   conv_ch_o,
  input  logic              conv_ack_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              irq_o,
  output logic              tshut_cru_o,
  output logic              tshut_gpio_o
);
  logic                          auto_en, qsel, pol, smp_vld;
  logic [NUM_CH-1:0]             shut_chk, int_en, gpio_rt, cru_rt, pend;
  logic [NUM_CH-1:0]             alarm_hit, shut_lat, hot;
  logic [NUM_CH-1:0][DATA_W-1:0] alarm_cmp, shut_cmp;
  logic [DEB_W-1:0]              alarm_deb, shut_deb;
  logic [PER_W-1:0]              per_norm, per_hot;
  logic [DATA_W-1:0]             smp_data;
  logic                          gpio_act, cru_act;

  // complemented reading, modulo the data width
  assign smp_data = qsel ? (DATA_W'(32'd1024) - conv_data_i) : conv_data_i;

  tsm_scheduler #(.NUM_CH(NUM_CH), .PER_W(PER_W)) i_sched (
    .clk_i, .rst_ni,
    .en_i      (auto_en),
    .tick_i,
    .per_norm_i(per_norm),
    .per_hot_i (per_hot),
    .hot_i     (|hot),
    .ack_i     (conv_ack_i),
    .req_o     (conv_req_o),
    .ch_o      (conv_ch_o),
    .smp_vld_o (smp_vld)
  );

  tsm_regs #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .DEB_W(DEB_W), .PER_W(PER_W),
    .INCREASING(INCREASING), .SHUT_PD_BIT(SHUT_PD_BIT)
  ) i_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .rdata_o,
    .smp_vld_i  (smp_vld),
    .smp_ch_i   (conv_ch_o),
    .smp_data_i (smp_data),
    .alarm_hit_i(alarm_hit),
    .shut_any_i (|shut_lat),
    .auto_en_o  (auto_en),
    .qsel_o     (qsel),
    .pol_o      (pol),
    .shut_chk_o (shut_chk),
    .int_en_o   (int_en),
    .gpio_rt_o  (gpio_rt),
    .cru_rt_o   (cru_rt),
    .alarm_cmp_o(alarm_cmp),
    .shut_cmp_o (shut_cmp),
    .alarm_deb_o(alarm_deb),
    .shut_deb_o (shut_deb),
    .per_norm_o (per_norm),
    .per_hot_o  (per_hot),
    .pend_o     (pend)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      tsm_chan_eval #(.DATA_W(DATA_W), .DEB_W(DEB_W), .INCREASING(INCREASING)) i_eval (
        .clk_i, .rst_ni,
        .smp_i      (smp_vld && (conv_ch_o == CH_W'(c))),
        .data_i     (smp_data),
        .alarm_cmp_i(alarm_cmp[c]),
        .shut_cmp_i (shut_cmp[c]),
        .alarm_deb_i(alarm_deb),
        .shut_deb_i (shut_deb),
        .shut_chk_i (shut_chk[c]),
        .alarm_hit_o(alarm_hit[c]),
        .shut_lat_o (shut_lat[c]),
        .hot_o      (hot[c])
      );
    end
  endgenerate

  assign irq_o        = |(pend & int_en);
  assign gpio_act     = |(shut_lat & gpio_rt);
  assign cru_act      = |(shut_lat & cru_rt);
  assign tshut_gpio_o = pol ? gpio_act : ~gpio_act;
  assign tshut_cru_o  = pol ? cru_act  : ~cru_act;
endmodule

// File: tb/test_thermal_scan_mon.sv
module test_thermal_scan_mon;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        we = 0, tick = 0;
  logic        conv_req, conv_ack = 0;
  logic [0:0]  conv_ch;
  logic [11:0] conv_data = 0;
  logic        irq, tshut_cru, tshut_gpio;

  thermal_scan_mon i_thermal_scan_mon (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .tick_i(tick), .conv_req_o(conv_req), .conv_ch_o(conv_ch),
    .conv_ack_i(conv_ack), .conv_data_i(conv_data), .irq_o(irq),
    .tshut_cru_o(tshut_cru), .tshut_gpio_o(tshut_gpio)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // tick every second cycle
  always @(negedge clk) tick <= ~tick;

  // converter stub: acknowledge two cycles after a request
  int adc_val[2];
  int dly = 0;
  always @(negedge clk) begin
    if (!conv_req || conv_ack) begin
      conv_ack <= 0; dly <= 0;
    end else if (dly == 1) begin
      conv_ack <= 1; conv_data <= 12'(adc_val[conv_ch]);
    end else dly <= dly + 1;
  end

  // ---------------- behavioural reference model ----------------
  int m_auto, m_inten, m_adeb, m_sdeb, m_pn, m_ph;
  int m_acmp[2], m_scmp[2], m_acnt[2], m_scnt[2];
  bit m_pend[2], m_shut[2], m_hot[2];
  int tcnt, next_ch;
  bit prev_req, started = 0;

  task automatic model_reset();
    m_auto = 0; m_inten = 0; m_adeb = 4; m_sdeb = 4; m_pn = 250; m_ph = 50;
    tcnt = 0; next_ch = 0; prev_req = 0;
    foreach (m_acmp[c]) begin
      m_acmp[c] = 'hFFF; m_scmp[c] = 'hFFF; m_acnt[c] = 0; m_scnt[c] = 0;
      m_pend[c] = 0; m_shut[c] = 0; m_hot[c] = 0;
    end
  endtask

  always @(posedge clk) if (started) begin
    bit hit[2];
    int per;
    hit[0] = 0; hit[1] = 0;
    per = (m_hot[0] || m_hot[1]) ? m_ph : m_pn;
    if (per == 0) per = 1;
    // R2/R3: interval length in ticks
    if (conv_req && !prev_req) begin
      chk(tcnt == per, "R2/R3 scan interval ticks", tcnt, per);
      tcnt = 0; next_ch = 0;
    end
    if (!m_auto[0]) tcnt = 0;
    else if (tick && !conv_req) tcnt++;
    prev_req = conv_req;
    if (conv_req && conv_ack) begin
      int c, v;
      bit ea, es;
      c = conv_ch;
      chk(c == next_ch, "R2 channel order", c, next_ch);
      next_ch++;
      v = m_auto[1] ? ((1024 - int'(conv_data)) & 'hFFF) : int'(conv_data);
      ea = v > m_acmp[c]; es = v > m_scmp[c];
      m_acnt[c] = ea ? ((m_acnt[c] < 255) ? m_acnt[c] + 1 : 255) : 0;
      m_scnt[c] = es ? ((m_scnt[c] < 255) ? m_scnt[c] + 1 : 255) : 0;
      hit[c] = ea && (m_acnt[c] >= m_adeb);
      if (m_auto[4+c] && es && m_scnt[c] >= m_sdeb) m_shut[c] = 1;
      m_hot[c] = ea || es;
    end
    if (we) begin
      case (addr)
        8'h04: m_auto = int'(wdata[15:0]);
        8'h08: m_inten = int'(wdata[15:0]);
        8'h0C: begin if (wdata[0]) m_pend[0] = 0; if (wdata[1]) m_pend[1] = 0; end
        8'h30: m_acmp[0] = int'(wdata[11:0]);
        8'h34: m_acmp[1] = int'(wdata[11:0]);
        8'h40: m_scmp[0] = int'(wdata[11:0]);
        8'h44: m_scmp[1] = int'(wdata[11:0]);
        8'h60: m_adeb = int'(wdata[7:0]);
        8'h64: m_sdeb = int'(wdata[7:0]);
        8'h68: m_pn = int'(wdata[15:0]);
        8'h6C: m_ph = int'(wdata[15:0]);
        default: ;
      endcase
    end
    if (hit[0]) m_pend[0] = 1;
    if (hit[1]) m_pend[1] = 1;
  end

  // per-clock comparison of the interrupt and shutdown outputs
  always @(negedge clk) if (started) begin
    bit e_irq, ga, ca, e_g, e_c;
    e_irq = (m_pend[0] && m_inten[0]) || (m_pend[1] && m_inten[1]);
    ga = (m_shut[0] && m_inten[4]) || (m_shut[1] && m_inten[5]);
    ca = (m_shut[0] && m_inten[8]) || (m_shut[1] && m_inten[9]);
    e_g = m_auto[8] ? ga : !ga;
    e_c = m_auto[8] ? ca : !ca;
    chk(irq == e_irq, "R7 irq_o", irq, e_irq);
    chk(tshut_gpio == e_g, "R9/R10/R11 tshut_gpio_o", tshut_gpio, e_g);
    chk(tshut_cru == e_c, "R9/R10/R11 tshut_cru_o", tshut_cru, e_c);
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_scans(input int n);
    repeat (n) @(negedge conv_req);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int reqs;
    adc_val[0] = 'h100; adc_val[1] = 'h100;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    started = 1;
    // R1 reset state
    #1;
    chk(irq == 0 && conv_req == 0, "R1 irq/req after reset", {irq, conv_req}, 0);
    chk(tshut_gpio == 1 && tshut_cru == 1, "R1 shutdown outputs inactive", {tshut_gpio, tshut_cru}, 3);
    rd(8'h04, d); chk(d == 0, "R1 control word", d, 0);
    rd(8'h60, d); chk(d == 4, "R1 alarm count default", d, 4);
    rd(8'h64, d); chk(d == 4, "R1 shutdown count default", d, 4);
    rd(8'h68, d); chk(d == 250, "R1 normal period default", d, 250);
    rd(8'h6C, d); chk(d == 50, "R1 high period default", d, 50);
    rd(8'h30, d); chk(d == 'hFFF, "R1 compare default", d, 'hFFF);

    // configuration
    wr(8'h68, 5); wr(8'h6C, 3); wr(8'h60, 2); wr(8'h64, 3);
    wr(8'h30, 'h800); wr(8'h34, 'h900); wr(8'h40, 'hA00); wr(8'h44, 'hA00);
    wr(8'h08, 32'h0000_0211);   // irq en ch0, ch0->gpio, ch1->cru
    wr(8'h04, 32'h0000_0031);   // scan on, shutdown check ch0/ch1, active low
    wait_scans(3);
    rd(8'h20, d); chk(d == 'h100, "R4 sample register ch0", d, 'h100);
    rd(8'h24, d); chk(d == 'h100, "R4 sample register ch1", d, 'h100);

    // R5 equality is not an excess
    adc_val[0] = 'h800;
    wait_scans(4);
    rd(8'h0C, d); chk(d[0] == 0, "R5 equal to limit does not count", d[0], 0);

    // R6 interrupted run does not reach the count of 2
    adc_val[0] = 'h801; wait_scans(1);
    adc_val[0] = 'h100; wait_scans(1);
    adc_val[0] = 'h801; wait_scans(1);
    adc_val[0] = 'h100; wait_scans(1);
    rd(8'h0C, d); chk(d[0] == 0, "R6 counter restarts on low sample", d[0], 0);
    adc_val[0] = 'h801; wait_scans(2);
    rd(8'h0C, d); chk(d[0] == 1, "R6 pending after two exceeding samples", d[0], 1);
    chk(irq == 1, "R7 irq with enabled pending", irq, 1);

    // R8 collision: clear in the same cycle as the setting sample
    @(negedge clk); #1;
    while (!(conv_ack && conv_ch == 0)) begin @(negedge clk); #1; end
    we = 1; addr = 8'h0C; wdata = 1;
    @(negedge clk); we = 0;
    #1 d = rdata;
    chk(d[0] == 1, "R8 set wins over clear in same cycle", d[0], 1);
    wait_scans(1);
    wr(8'h0C, 1);
    rd(8'h0C, d); chk(d[0] == 0, "R8 write-one clears while idle", d[0], 0);

    // R7 masked pending: ch1 pending without enable
    adc_val[0] = 'h100; adc_val[1] = 'h901;
    wait_scans(3);
    wr(8'h0C, 1);
    rd(8'h0C, d); chk(d[1] == 1 && d[0] == 0, "R7 masked ch1 pending", d[1:0], 2);
    chk(irq == 0, "R7 irq masked", irq, 0);

    // R4 complemented reading
    adc_val[1] = 'h100;
    wr(8'h04, 32'h0000_0033);
    wait_scans(2);
    rd(8'h20, d); chk(d == 'h300, "R4 complemented sample", d, 'h300);
    wr(8'h04, 32'h0000_0031);
    wait_scans(2);

    // R9 shutdown via reset-controller route on ch1
    adc_val[1] = 'hA01;
    wait_scans(2);
    chk(tshut_cru == 1, "R9 not yet at shutdown count", tshut_cru, 1);
    wait_scans(2);
    chk(tshut_cru == 0 && tshut_gpio == 1, "R9 cru route asserted", {tshut_cru, tshut_gpio}, 1);
    rd(8'h0C, d); chk(d[8] == 1, "R8 shutdown status bit", d[8], 1);
    wr(8'h0C, d & ~32'h100);
    rd(8'h0C, d); chk(d[8] == 1, "R8 status unaffected by write", d[8], 1);
    adc_val[1] = 'h100;
    wait_scans(3);
    chk(tshut_cru == 0, "R11 shutdown stays latched", tshut_cru, 0);

    // R10 polarity
    wr(8'h04, 32'h0000_0131);
    @(negedge clk);
    chk(tshut_cru == 1 && tshut_gpio == 0, "R10 active-high outputs", {tshut_cru, tshut_gpio}, 2);

    // R9 check disabled for ch0: no gpio shutdown
    wr(8'h04, 32'h0000_0121);
    adc_val[0] = 'hA01;
    wait_scans(5);
    chk(tshut_gpio == 0, "R9 unchecked channel no shutdown", tshut_gpio, 0);

    // R12 scanning disabled
    wr(8'h04, 32'h0000_0120);
    reqs = 0;
    repeat (60) begin @(negedge clk); if (conv_req) reqs++; end
    chk(reqs == 0, "R12 no requests while disabled", reqs, 0);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule